// File: doc/BRIEF.md
# Fractional PLL Divider Parameter Calculator

This block converts the reference divide value M and the feedback multiply value N into the settings that a fractional feedback divider needs. It finds how many times M can be doubled before it exceeds N. From that it derives a pre-scale exponent P, forms the scaled multiplier N′ = N·2^P, and divides N′ by M to get an integer part Q and a remainder R. Alongside this it maps a VCO frequency, given in whole MHz, onto a two-bit band code.

A single `start` pulse captures all inputs. The block then spends one cycle per doubling step and one cycle per quotient bit, using a restoring divider. It reports the results with a one-cycle `done` pulse. Inputs that cannot form a valid ratio (M of zero, or N below M) end the run early with an error flag and all results at zero. The results stay on the outputs until the next run completes.

Top module: `frac_div_calc`

## Requirements
- R1: After reset, `busy`, `done` and `err` are low and every result output is zero.
- R2: For valid inputs, with k the largest integer such that M·2^k ≤ N, `p_out` = 4 − k when k ≤ 4 and 0 when k > 4.
- R3: `nscaled` = N·2^P, where P is the value reported on `p_out` (16 bits wide).
- R4: `q_out` = floor(N′/M), replaced by 63 when the quotient exceeds 63.
- R5: `r_out` = N′ mod M, which equals N′ − M·Q whenever Q is not saturated.
- R6: `vco_band` is 0 for a frequency below 125, 1 for 125 to 149, 2 for 150 to 174 and 3 for 175 and above (MHz, taken from `vco_mhz` at start).
- R7: For valid inputs, `done` is high for exactly one cycle, k+17 clock edges after the edge that accepts `start`. `busy` is high from that accepting edge until `done` rises, and is low while `done` is high.
- R8: When the captured M is 0 or N < M, `done` and `err` are high together one edge after start is accepted, and every result output (including `vco_band`) reads zero. `err` is low at all other times.
- R9: A `start` that arrives while `busy` is high is ignored: the run in progress finishes with its own results and timing.
- R10: The result outputs change only on the edge that raises `done`; otherwise they hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Capture inputs and begin a run when idle |
| m_val | input | 9 | Reference divide value M |
| n_val | input | 12 | Feedback multiply value N |
| vco_mhz | input | 8 | VCO frequency in MHz for band coding |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Invalid inputs, valid with `done` |
| p_out | output | 3 | Pre-scale exponent P |
| nscaled | output | 16 | Scaled multiplier N′ |
| q_out | output | 6 | Saturated integer quotient Q |
| r_out | output | 9 | Remainder R |
| vco_band | output | 2 | VCO band code |

## Verification
The worked ratios 4/1 and 11/2 check the basic chain through P, N′, Q and R. A ratio of exactly 1 gives the largest scale, and exact powers of two such as 80/5 land on the k = 4 boundary where P first reaches zero, while 79/5 sits just below it. Large ratios such as 4095/1 and 1000/7 clamp P at zero and overflow Q, which separates saturation from a plain truncated quotient and shows the remainder at its full value. Band codes are tried on both sides of every threshold. A second start fired mid-run, error cases, and a random batch compared cycle by cycle confirm the latency formula, the hold behaviour and that a busy block ignores start.

// File: rtl/frac_div_calc.sv
module frac_div_calc #(
  parameter int MW    = 9,
  parameter int NW    = 12,
  parameter int FW    = 8,
  parameter int QW    = 6,
  parameter int PBASE = 4,
  parameter int B1    = 125,
  parameter int B2    = 150,
  parameter int B3    = 175
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic [MW-1:0]         m_val,
  input  logic [NW-1:0]         n_val,
  input  logic [FW-1:0]         vco_mhz,
  output logic                  busy,
  output logic                  done,
  output logic                  err,
  output logic [$clog2(PBASE+1)-1:0] p_out,
  output logic [NW+PBASE-1:0]   nscaled,
  output logic [QW-1:0]         q_out,
  output logic [MW-1:0]         r_out,
  output logic [1:0]            vco_band
);
  localparam int PW   = $clog2(PBASE+1);
  localparam int NPW  = NW + PBASE;
  localparam int KW   = $clog2(NW+1);
  localparam int CW   = $clog2(NPW);
  localparam int XW   = NW + MW + 1;
  localparam int QMAX = (1 << QW) - 1;

  typedef enum logic [1:0] {S_IDLE, S_LOG, S_DIV} state_t;
  state_t state;

  logic [MW-1:0]  m_q, rem_q;
  logic [NW-1:0]  n_q;
  logic [FW-1:0]  f_q;
  logic [KW-1:0]  k_q;
  logic [CW-1:0]  cnt;
  logic [NPW-1:0] quo_q, np_q;

  logic [XW-1:0]  probe;
  logic           bad, fits, ge;
  logic [PW-1:0]  p_calc;
  logic [MW:0]    sh, rem_n;
  logic [NPW-1:0] quo_n;
  logic [1:0]     band_calc;

  assign probe  = {{(NW+1){1'b0}}, m_q} << (k_q + 1'b1);
  assign fits   = probe <= {{(MW+1){1'b0}}, n_q};
  assign bad    = (m_q == '0) || (n_q < {{(NW-MW){1'b0}}, m_q});
  assign p_calc = (k_q > KW'(PBASE)) ? '0 : PW'(KW'(PBASE) - k_q);
  assign sh     = {rem_q, quo_q[NPW-1]};
  assign ge     = sh >= {1'b0, m_q};
  assign rem_n  = ge ? sh - {1'b0, m_q} : sh;
  assign quo_n  = {quo_q[NPW-2:0], ge};
  assign band_calc = (f_q < FW'(B1)) ? 2'd0 :
                     (f_q < FW'(B2)) ? 2'd1 :
                     (f_q < FW'(B3)) ? 2'd2 : 2'd3;
  assign busy   = state != S_IDLE;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE;
      m_q <= '0; n_q <= '0; f_q <= '0; k_q <= '0; cnt <= '0;
      rem_q <= '0; quo_q <= '0; np_q <= '0;
      done <= 1'b0; err <= 1'b0;
      p_out <= '0; nscaled <= '0; q_out <= '0; r_out <= '0; vco_band <= '0;
    end else begin
      done <= 1'b0;
      err  <= 1'b0;
      case (state)
        S_IDLE: if (start) begin
          m_q <= m_val; n_q <= n_val; f_q <= vco_mhz; k_q <= '0;
          state <= S_LOG;
        end
        S_LOG: begin
          if (bad) begin
            done <= 1'b1; err <= 1'b1;
            p_out <= '0; nscaled <= '0; q_out <= '0; r_out <= '0; vco_band <= '0;
            state <= S_IDLE;
          end else if (fits) begin
            k_q <= k_q + 1'b1;
          end else begin
            np_q  <= NPW'(n_q) << p_calc;
            quo_q <= NPW'(n_q) << p_calc;
            rem_q <= '0;
            cnt   <= '0;
            state <= S_DIV;
          end
        end
        S_DIV: begin
          rem_q <= rem_n[MW-1:0];
          quo_q <= quo_n;
          cnt   <= cnt + 1'b1;
          if (cnt == CW'(NPW-1)) begin
            done     <= 1'b1;
            p_out    <= p_calc;
            nscaled  <= np_q;
            q_out    <= (quo_n > NPW'(QMAX)) ? QW'(QMAX) : quo_n[QW-1:0];
            r_out    <= rem_n[MW-1:0];
            vco_band <= band_calc;
            state    <= S_IDLE;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/frac_div_calc_chk.sv
module frac_div_calc_chk #(
  parameter int MW = 9,
  parameter int NW = 12,
  parameter int FW = 8,
  parameter int QW = 6,
  parameter int PBASE = 4,
  parameter int B1 = 125,
  parameter int B3 = 175
) (
  input logic clk,
  input logic rst_n,
  input logic busy,
  input logic done,
  input logic err,
  input logic [$clog2(PBASE+1)-1:0] p_out,
  input logic [NW+PBASE-1:0] nscaled,
  input logic [QW-1:0] q_out,
  input logic [MW-1:0] r_out,
  input logic [1:0] vco_band,
  input logic [MW-1:0] m_q,
  input logic [FW-1:0] f_q
);
  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_done_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  assert_err_with_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> done);
  assert_err_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (p_out == '0 && nscaled == '0 && q_out == '0 && r_out == '0 && vco_band == '0));
  assert_p_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !err) |-> (int'(p_out) <= PBASE));
  assert_rem_below_m_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !err) |-> (r_out < m_q));
  assert_band_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !err && f_q >= FW'(B3)) |-> (vco_band == 2'd3));
  assert_band_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !err && f_q < FW'(B1)) |-> (vco_band == 2'd0));
  assert_busy_ends_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);
  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(p_out) && $stable(nscaled) && $stable(q_out) &&
               $stable(r_out) && $stable(vco_band)));
endmodule

bind frac_div_calc frac_div_calc_chk #(
  .MW(MW), .NW(NW), .FW(FW), .QW(QW), .PBASE(PBASE), .B1(B1), .B3(B3)
) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .err(err),
  .p_out(p_out), .nscaled(nscaled), .q_out(q_out), .r_out(r_out),
  .vco_band(vco_band), .m_q(m_q), .f_q(f_q)
);

// File: tb/tb_frac_div_calc.sv
module tb_frac_div_calc;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [8:0]  m_val = '0;
  logic [11:0] n_val = '0;
  logic [7:0]  vco_mhz = '0;
  logic busy, done, err;
  logic [2:0]  p_out;
  logic [15:0] nscaled;
  logic [5:0]  q_out;
  logic [8:0]  r_out;
  logic [1:0]  vco_band;

  int n_cmp = 0, n_bad = 0, cyc = 0;

  frac_div_calc dut (
    .clk(clk), .rst_n(rst_n), .start(start), .m_val(m_val), .n_val(n_val),
    .vco_mhz(vco_mhz), .busy(busy), .done(done), .err(err), .p_out(p_out),
    .nscaled(nscaled), .q_out(q_out), .r_out(r_out), .vco_band(vco_band)
  );

  always #2.5 clk = ~clk;

  int left = 0;
  int e_busy = 0, e_done = 0, e_err = 0;
  int e_p = 0, e_np = 0, e_q = 0, e_r = 0, e_b = 0;
  int x_err = 0, x_p = 0, x_np = 0, x_q = 0, x_r = 0, x_b = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      left = 0; e_busy = 0; e_done = 0; e_err = 0;
      e_p = 0; e_np = 0; e_q = 0; e_r = 0; e_b = 0;
    end else begin
      e_done = 0; e_err = 0;
      if (left > 0) begin
        left--;
        if (left == 0) begin
          e_done = 1; e_busy = 0; e_err = x_err;
          e_p = x_p; e_np = x_np; e_q = x_q; e_r = x_r; e_b = x_b;
        end
      end else if (start) begin
        int m, n, f, k, qq;
        m = m_val; n = n_val; f = vco_mhz;
        e_busy = 1;
        if (m == 0 || n < m) begin
          x_err = 1; x_p = 0; x_np = 0; x_q = 0; x_r = 0; x_b = 0;
          left = 1;
        end else begin
          k = 0;
          while ((m << (k + 1)) <= n) k++;
          x_err = 0;
          x_p = (k > 4) ? 0 : 4 - k;
          x_np = n << x_p;
          qq = x_np / m;
          x_q = (qq > 63) ? 63 : qq;
          x_r = x_np % m;
          x_b = (f < 125) ? 0 : (f < 150) ? 1 : (f < 175) ? 2 : 3;
          left = k + 17;
        end
      end
    end
  end

  task automatic chk(string tag, string what, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", tag, what, act, exp, cyc);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      chk("R7", "busy", busy, e_busy);
      chk("R7", "done", done, e_done);
      chk("R8", "err", err, e_err);
      chk(e_done ? (e_err ? "R8" : "R2") : "R10", "p_out", p_out, e_p);
      chk(e_done ? (e_err ? "R8" : "R3") : "R10", "nscaled", nscaled, e_np);
      chk(e_done ? (e_err ? "R8" : "R4") : "R10", "q_out", q_out, e_q);
      chk(e_done ? (e_err ? "R8" : "R5") : "R10", "r_out", r_out, e_r);
      chk(e_done ? (e_err ? "R8" : "R6") : "R10", "vco_band", vco_band, e_b);
    end
  end

  task automatic run(int m, int n, int f);
    @(negedge clk);
    m_val = 9'(m); n_val = 12'(n); vco_mhz = 8'(f); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (32) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk("R1", "reset busy", busy, 0);
    chk("R1", "reset done", done, 0);
    chk("R1", "reset err", err, 0);
    chk("R1", "reset results", int'(p_out) + int'(nscaled) + int'(q_out) + int'(r_out) + int'(vco_band), 0);

    run(1, 4, 100);      // R2 R3 worked case
    run(2, 11, 148);     // R4 worked case
    run(1, 1, 124);      // largest scale, band edge R6
    run(3, 7, 125);      // nonzero remainder R5
    run(511, 4095, 149);
    run(5, 80, 150);     // k = 4 boundary
    run(5, 79, 174);
    run(1, 4095, 175);   // saturated quotient R4
    run(7, 1000, 255);   // clamp P, remainder R5
    run(0, 5, 200);      // R8 zero divide value
    run(10, 9, 200);     // R8 N below M

    // R9: second start while busy is ignored
    @(negedge clk);
    m_val = 9'd3; n_val = 12'd200; vco_mhz = 8'd160; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (4) @(negedge clk);
    m_val = 9'd1; n_val = 12'd3; vco_mhz = 8'd10; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (32) @(negedge clk);

    for (int i = 0; i < 40; i++) begin
      int m, n;
      m = $urandom_range(511, 1);
      n = $urandom_range(4095, m);
      run(m, n, $urandom_range(255, 0));
    end
    run(9, 4, 130);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule